// File: doc/BRIEF.md
# Prefix Lookup with Multipath Selection

This block is a small IPv4 forwarding table. A request carries a 32-bit destination address. The block returns either a next-hop index or a drop indication. Each table slot holds a prefix, a prefix length, a next-hop index and a valid flag. A plain write port loads one slot per cycle.

A lookup first keeps every valid slot whose prefix covers the destination. From those it keeps only the slots with the greatest prefix length. Only that pruned set is eligible for multipath spreading. The slot chosen from it is the one that was selected longest ago, so entries of different lengths never share traffic. Each slot carries a selection stamp. The stamp changes only when that slot is chosen, or when the slot is rewritten; a rewritten slot counts as the oldest.

Requests and responses are valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Its response appears two cycles later when the output is not stalled. A response that is not taken stays on the pins, unchanged, until `rsp_ready` is high. While a response is held, `req_ready` is low and nothing inside the pipeline moves.

Top module: `route_pick`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid` is low and every slot is invalid, so a lookup gets a drop response.
- R2: A slot with length L (1..32) matches when the top L bits of the destination equal the top L bits of its prefix. Length 0 matches every address. A written length above 32 is stored as 32.
- R3: When matching slots have different lengths, the response always comes from a slot with the greatest matching length. A shorter match is never returned.
- R4: When no valid slot matches, the response has `rsp_drop`=1 and `rsp_nh`=0. Otherwise `rsp_drop`=0.
- R5: When exactly one slot survives pruning, its next-hop is returned on every lookup of that destination.
- R6: When several slots survive, the one selected least recently is returned. A slot's stamp is updated only when that slot is the one returned.
- R7: Survivors with equal stamps go to the lowest slot index. A slot that was just written counts as never selected.
- R8: A write that clears a slot's valid flag removes the slot from every lookup accepted after the write's clock edge.
- R9: With `rsp_ready` high, a request accepted at edge k gives `rsp_valid` high after edge k+1. Back-to-back requests give responses in order, one per cycle.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_nh`, `rsp_drop` and `rsp_valid` hold, `req_ready` is 0, and no stamp changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 32 | Destination address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_nh | output | NH_W | Selected next-hop index (0 on drop) |
| rsp_drop | output | 1 | No route: destination unreachable |
| wr_en | input | 1 | Write one table slot |
| wr_idx | input | IDX_W | Slot to write |
| wr_valid | input | 1 | Valid flag for the written slot |
| wr_prefix | input | 32 | Prefix for the written slot |
| wr_len | input | 6 | Prefix length (values above 32 clamp to 32) |
| wr_nh | input | NH_W | Next-hop index for the written slot |

## Verification
The bench sweeps the prefix length across 0, small, mid and full values, plus a clamped value. It probes the bit just inside and just outside each mask. An off-by-one mask would turn a near miss into a hit. A table that nests a /16, a /20 and a default route shows whether a shorter route ever leaks into a multipath set. Such a design would send a more specific destination out the wrong next-hop. Repeated lookups over a three-way group, a rewrite and a removal check round-robin order, tie-break by index and immediate withdrawal. A pipeline that updated stamps during a stall, or at the wrong stage, would repeat or skip a next-hop in the back-pressure and back-to-back cases. A long pseudo-random table sweep compares every response with an arithmetic model.

// File: rtl/route_pkg.sv
package route_pkg;
  // IPv4 destinations only
  localparam int ADDR_W = 32;
  // enough bits to hold 0..32
  localparam int LEN_W  = 6;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] pfx;
    logic [LEN_W-1:0]  len;
  } route_key_t;

  // Mask with the top 'len' bits set; len 0 gives an all-zero mask.
  function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    return ~({ADDR_W{1'b1}} >> len);
  endfunction
endpackage

// File: rtl/route_table.sv
module route_table
  import route_pkg::*;
#(
  parameter int N       = 8,
  parameter int NH_W    = 4,
  parameter int STAMP_W = 32,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_vld,
  input  logic [ADDR_W-1:0]  wr_pfx,
  input  logic [LEN_W-1:0]   wr_len,
  input  logic [NH_W-1:0]    wr_nh,
  input  logic               use_en,
  input  logic [IDX_W-1:0]   use_idx,
  output route_key_t         keys  [N],
  output logic [NH_W-1:0]    nh    [N],
  output logic [STAMP_W-1:0] stamp [N]
);
  logic [LEN_W-1:0]   len_cl;
  logic [STAMP_W-1:0] use_cnt;

  assign len_cl = (wr_len > LEN_W'(ADDR_W)) ? LEN_W'(ADDR_W) : wr_len;

  // Stamp source: 0 is reserved for "never selected", so counting starts at 1.
  always_ff @(posedge clk) begin
    if (!rst_n)      use_cnt <= STAMP_W'(1);
    else if (use_en) use_cnt <= use_cnt + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    route_key_t         key_q;
    logic [NH_W-1:0]    nh_q;
    logic [STAMP_W-1:0] st_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        key_q <= '0;
        nh_q  <= '0;
        st_q  <= '0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        key_q.vld <= wr_vld;
        key_q.pfx <= wr_pfx;
        key_q.len <= len_cl;
        nh_q      <= wr_nh;
        st_q      <= '0;           // rewritten slot counts as oldest
      end else if (use_en && use_idx == IDX_W'(i)) begin
        st_q      <= use_cnt;
      end
    end

    assign keys[i]  = key_q;
    assign nh[i]    = nh_q;
    assign stamp[i] = st_q;
  end
endmodule

// File: rtl/route_prune.sv
module route_prune
  import route_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  route_key_t        keys [N],
  output logic [N-1:0]      surv
);
  logic [N-1:0]     hit;
  logic [LEN_W-1:0] best;

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = keys[i].vld &&
                    (((addr ^ keys[i].pfx) & len_mask(keys[i].len)) == '0);
  end

  // Longest length among the hits
  always_comb begin
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i] && keys[i].len > best) best = keys[i].len;
    end
  end

  // Only the most specific hits stay in the multipath set
  for (genvar i = 0; i < N; i++) begin : g_surv
    assign surv[i] = hit[i] && (keys[i].len == best);
  end
endmodule

// File: rtl/route_lru_pick.sv
module route_lru_pick #(
  parameter int N       = 8,
  parameter int STAMP_W = 32,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       cand,
  input  logic [STAMP_W-1:0] stamp [N],
  output logic [N-1:0]       pick_oh,
  output logic [IDX_W-1:0]   pick_idx,
  output logic               found
);
  logic [STAMP_W-1:0] oldest;

  // Ascending scan with a strict compare: equal stamps keep the lower index.
  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    oldest   = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || stamp[i] < oldest)) begin
        found    = 1'b1;
        pick_idx = IDX_W'(i);
        oldest   = stamp[i];
      end
    end
  end

  always_comb begin
    pick_oh = '0;
    if (found) pick_oh[pick_idx] = 1'b1;
  end
endmodule

// File: rtl/route_pick.sv
module route_pick
  import route_pkg::*;
#(
  parameter int N_ROUTES = 8,
  parameter int NH_W     = 4,
  parameter int STAMP_W  = 32,
  localparam int IDX_W   = (N_ROUTES > 1) ? $clog2(N_ROUTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NH_W-1:0]   rsp_nh,
  output logic              rsp_drop,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_prefix,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [NH_W-1:0]   wr_nh
);
  route_key_t          keys   [N_ROUTES];
  logic [NH_W-1:0]     nh_tab [N_ROUTES];
  logic [STAMP_W-1:0]  stamps [N_ROUTES];

  logic [N_ROUTES-1:0] surv_now, a_surv, live, cand, pick_oh;
  logic [IDX_W-1:0]    pick_idx;
  logic                found;
  logic                a_vld;
  logic                advance, use_en;
  logic                rsp_valid_q, rsp_drop_q;
  logic [NH_W-1:0]     rsp_nh_q, nh_sel;

  // Whole pipeline moves unless a response sits untaken
  assign advance   = !(rsp_valid_q && !rsp_ready);
  assign req_ready = advance;
  assign use_en    = advance && a_vld && found;

  route_table #(
    .N       (N_ROUTES),
    .NH_W    (NH_W),
    .STAMP_W (STAMP_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_vld  (wr_valid),
    .wr_pfx  (wr_prefix),
    .wr_len  (wr_len),
    .wr_nh   (wr_nh),
    .use_en  (use_en),
    .use_idx (pick_idx),
    .keys    (keys),
    .nh      (nh_tab),
    .stamp   (stamps)
  );

  // Stage A: match and longest-length pruning against the request address
  route_prune #(.N(N_ROUTES)) u_prune (
    .addr (req_addr),
    .keys (keys),
    .surv (surv_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_vld  <= 1'b0;
      a_surv <= '0;
    end else if (advance) begin
      a_vld  <= req_valid;
      a_surv <= surv_now;
    end
  end

  // Stage B: drop survivors withdrawn since stage A, then pick the oldest
  for (genvar i = 0; i < N_ROUTES; i++) begin : g_live
    assign live[i] = keys[i].vld;
  end
  assign cand = a_surv & live;

  route_lru_pick #(
    .N       (N_ROUTES),
    .STAMP_W (STAMP_W)
  ) u_pick (
    .cand     (cand),
    .stamp    (stamps),
    .pick_oh  (pick_oh),
    .pick_idx (pick_idx),
    .found    (found)
  );

  always_comb begin
    nh_sel = '0;
    for (int i = 0; i < N_ROUTES; i++) begin
      if (pick_oh[i]) nh_sel = nh_sel | nh_tab[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_drop_q  <= 1'b0;
      rsp_nh_q    <= '0;
    end else if (advance) begin
      rsp_valid_q <= a_vld;
      rsp_drop_q  <= a_vld && !found;
      rsp_nh_q    <= nh_sel;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_drop  = rsp_drop_q;
  assign rsp_nh    = rsp_nh_q;
endmodule

// File: rtl/route_pick_chk.sv
module route_pick_chk #(
  parameter int N    = 8,
  parameter int NH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [NH_W-1:0] rsp_nh,
  input logic            rsp_drop,
  input logic [N-1:0]    cand,
  input logic [N-1:0]    pick_oh
);
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_nh) && $stable(rsp_drop)));

  // R10
  no_accept_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R4
  drop_nh_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_drop) |-> (rsp_nh == '0));

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 rsp_valid);

  // R6
  pick_in_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pick_oh & ~cand) == '0) && $onehot0(pick_oh));

  // R4
  pick_when_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |-> ($countones(pick_oh) == 1));
endmodule

bind route_pick route_pick_chk #(.N(N_ROUTES), .NH_W(NH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_nh    (rsp_nh),
  .rsp_drop  (rsp_drop),
  .cand      (cand),
  .pick_oh   (pick_oh)
);

// File: tb/sim_route_pick.sv
module sim_route_pick;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int NH_W = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [NH_W-1:0] rsp_nh;
  logic        rsp_drop;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_prefix = '0;
  logic [5:0]  wr_len = '0;
  logic [NH_W-1:0] wr_nh = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  route_pick #(.N_ROUTES(N), .NH_W(NH_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_nh(rsp_nh), .rsp_drop(rsp_drop),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_prefix(wr_prefix),
    .wr_len(wr_len), .wr_nh(wr_nh)
  );

  int nchk = 0;
  int nerr = 0;

  // Reference model of the table
  bit          m_vld [N];
  logic [31:0] m_pfx [N];
  int          m_len [N];
  int          m_nh  [N];
  longint      m_st  [N];
  longint      m_cnt = 1;
  logic [31:0] rs = 32'h1357_9bdf;

  task automatic check_eq(string req, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic bit m_match(int i, logic [31:0] a);
    if (!m_vld[i]) return 0;
    if (m_len[i] == 0) return 1;
    return ((a >> (32 - m_len[i])) == (m_pfx[i] >> (32 - m_len[i])));
  endfunction

  // Index the design should return, or -1 for drop
  function automatic int m_pick(logic [31:0] a);
    int bl = -1;
    int sel = -1;
    for (int i = 0; i < N; i++)
      if (m_match(i, a) && m_len[i] > bl) bl = m_len[i];
    for (int i = 0; i < N; i++)
      if (m_match(i, a) && m_len[i] == bl)
        if (sel < 0 || m_st[i] < m_st[sel]) sel = i;
    return sel;
  endfunction

  task automatic m_use(int e);
    if (e >= 0) begin
      m_st[e] = m_cnt;
      m_cnt++;
    end
  endtask

  task automatic write_slot(int idx, bit v, logic [31:0] pfx, int len, int nh);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_valid = v; wr_prefix = pfx;
    wr_len = 6'(len); wr_nh = NH_W'(nh);
    @(negedge clk);
    wr_en = 1'b0;
    m_vld[idx] = v; m_pfx[idx] = pfx; m_len[idx] = (len > 32) ? 32 : len;
    m_nh[idx] = nh; m_st[idx] = 0;
  endtask

  task automatic lookup(logic [31:0] a, string req);
    int e;
    e = m_pick(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check_eq(req, "rsp_valid", rsp_valid, 1);
    check_eq(req, "rsp_drop", rsp_drop, (e < 0) ? 1 : 0);
    check_eq(req, "rsp_nh", rsp_nh, (e < 0) ? 0 : m_nh[e]);
    m_use(e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    int lens [8];
    logic [31:0] p;
    logic [31:0] ba [4];
    int be [4];
    int e1, e2;

    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_pfx[i] = '0; m_len[i] = 0; m_nh[i] = 0; m_st[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle state after reset, empty table drops
    check_eq("R1", "req_ready", req_ready, 1);
    check_eq("R1", "rsp_valid", rsp_valid, 0);
    lookup(32'h0A00_0001, "R1");
    lookup(32'hFFFF_FFFF, "R4");

    // R2: mask boundary sweep, including clamp of length 40 to 32
    lens = '{0, 1, 7, 16, 23, 31, 32, 40};
    p = 32'hC0A8_5A3C;
    foreach (lens[k]) begin
      int lc;
      lc = (lens[k] > 32) ? 32 : lens[k];
      write_slot(0, 1, p, lens[k], 5);
      lookup(p, "R2");
      if (lc > 0)  lookup(p ^ (32'h1 << (32 - lc)), "R2");
      if (lc < 32) lookup(p ^ (32'h1 << (31 - lc)), "R2");
      lookup(~p, "R2");
    end
    write_slot(0, 0, '0, 0, 0);

    // R3/R5: nested /16, /20 and default route; single survivors repeat
    write_slot(0, 1, 32'h0A01_0000, 16, 1);
    write_slot(1, 1, 32'h0A01_0000, 20, 2);
    write_slot(2, 1, 32'h0000_0000, 0, 3);
    for (int x = 0; x < 32; x++) lookup(32'h0A01_0000 | (32'(x) << 11), "R3");
    for (int r = 0; r < 3; r++) begin
      lookup(32'h0A01_0F01, "R5");
      lookup(32'h0A01_8001, "R5");
      lookup(32'h0B00_0001, "R5");
    end

    // R6/R7: three-way /16 group; shorter /8 must never join
    write_slot(3, 1, 32'h0A02_0000, 16, 4);
    write_slot(4, 1, 32'h0A02_0000, 16, 5);
    write_slot(5, 1, 32'h0A02_FFFF, 16, 6);
    write_slot(6, 1, 32'h0A00_0000, 8, 7);
    for (int r = 0; r < 7; r++) lookup(32'h0A02_1234, "R6");
    lookup(32'h0A01_0F01, "R6");
    write_slot(4, 1, 32'h0A02_0000, 16, 9);
    lookup(32'h0A02_0001, "R7");
    lookup(32'h0A02_0001, "R7");
    lookup(32'h0A02_0001, "R7");

    // R8: withdrawal takes effect on the next lookup
    write_slot(3, 0, 32'h0A02_0000, 16, 4);
    for (int r = 0; r < 4; r++) lookup(32'h0A02_0077, "R8");
    write_slot(1, 0, 32'h0A01_0000, 20, 2);
    lookup(32'h0A01_0F01, "R8");

    // R10: stall holds the response, blocks requests, freezes stamps
    e1 = m_pick(32'h0A02_0042); m_use(e1);
    e2 = m_pick(32'h0A02_0042); m_use(e2);
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0A02_0042;
    @(negedge clk);
    check_eq("R10", "req_ready before stall", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      check_eq("R10", "held rsp_valid", rsp_valid, 1);
      check_eq("R10", "held rsp_nh", rsp_nh, m_nh[e1]);
      check_eq("R10", "req_ready in stall", req_ready, 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check_eq("R10", "second rsp_valid", rsp_valid, 1);
    check_eq("R10", "second rsp_nh", rsp_nh, m_nh[e2]);
    @(negedge clk);
    check_eq("R10", "drained rsp_valid", rsp_valid, 0);

    // R9: four back-to-back requests, one response per cycle in order
    ba = '{32'h0A02_0001, 32'h0A01_0F01, 32'h0A02_0002, 32'h0C00_0000};
    for (int k = 0; k < 4; k++) begin
      be[k] = m_pick(ba[k]);
      m_use(be[k]);
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check_eq("R9", "burst rsp_valid", rsp_valid, 1);
        check_eq("R9", "burst rsp_drop", rsp_drop, (be[i-2] < 0) ? 1 : 0);
        check_eq("R9", "burst rsp_nh", rsp_nh, (be[i-2] < 0) ? 0 : m_nh[be[i-2]]);
      end
      req_valid = (i < 4);
      req_addr  = ba[(i < 4) ? i : 0];
    end
    @(negedge clk);
    check_eq("R9", "burst end rsp_valid", rsp_valid, 0);

    // R2/R3/R6: pseudo-random tables against the model
    lens = '{0, 8, 12, 16, 16, 20, 24, 40};
    for (int t = 0; t < 8; t++) begin
      for (int i = 0; i < N; i++) begin
        logic [31:0] r;
        r = rnd();
        write_slot(i, (r[1:0] != 2'b00), 32'h0A00_0000 | (r & 32'h0003_3000),
                   lens[r[10:8]], int'(r[27:24]));
      end
      for (int q = 0; q < 50; q++) begin
        logic [31:0] r;
        r = rnd();
        lookup((r[31:29] == 3'b000) ? r : (32'h0A00_0000 | (r & 32'h0003_3FFF)), "R3");
      end
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule